// File: doc/BRIEF.md
# Prioritized Vectored Interrupter with Acknowledge Chain

This block is the requesting side of a backplane interrupt scheme. A one-cycle local trigger makes an interrupt pending at a configured priority level from 1 to 7. While the interrupt is pending, the block asserts the request line for that level. It then waits for the handler's acknowledge cycle.

During that cycle the handler presents a level on three address bits under the address strobe, with the incoming chain signal asserted. If the level matches the configured level and an interrupt is pending, the block claims the cycle. It waits for a data strobe and then returns its 8-bit status/ID vector with a transfer acknowledge, just as a slave answers a read. In every other case it passes the chain signal on to the next slot, so an active interrupter closer to the handler always wins a tie.

All backplane signals are shown active-high and are synchronous to `clk`. Level and vector selects are ordinary configuration inputs.

Top module: `vecIntr`

## Requirements
- R1: `irqOut` has at most one bit set. Bit L-1 is high exactly while an interrupt is pending and `cfgLevel` equals L (1 to 7).
- R2: An acknowledge cycle begins when `chainIn` and `addrStrobe` are sampled high in the idle state. If at that point `lvlAddr` differs from `cfgLevel`, or nothing is pending, `chainOut` rises one cycle later and `xferAck` stays low for the whole cycle.
- R3: If the level matches and an interrupt is pending, `chainOut` stays low. `xferAck` rises, with `vecOut` equal to `cfgVector`, one cycle after a nonzero `dataStrobe` is first sampled.
- R4: The pending interrupt, and with it its request line, is cleared at the edge where `xferAck` rises.
- R5: `xferAck` falls and `vecOut` returns to zero one cycle after `dataStrobe` is sampled as 2'b00. `vecOut` is zero whenever `xferAck` is low.
- R6: A forwarded `chainOut` falls one cycle after `addrStrobe` is sampled low.
- R7: A trigger sampled in the same cycle as the vector delivery leaves a new interrupt pending, so the request line stays asserted.
- R8: With `cfgLevel` = 0 a trigger creates no request, and every acknowledge cycle is forwarded.
- R9: After reset `irqOut`, `chainOut`, `xferAck` and `vecOut` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| trigPulse | input | 1 | Local interrupt trigger, one cycle |
| cfgLevel | input | 3 | Configured priority level, 0 disables |
| cfgVector | input | 8 | Status/ID vector returned on acknowledge |
| chainIn | input | 1 | Acknowledge chain from the left neighbour |
| addrStrobe | input | 1 | Address strobe of the acknowledge cycle |
| lvlAddr | input | 3 | Level being serviced (address bits 1 to 3) |
| dataStrobe | input | 2 | Data strobes from the handler |
| irqOut | output | 7 | Request lines, bit i for level i+1 |
| chainOut | output | 1 | Acknowledge chain to the right neighbour |
| xferAck | output | 1 | Transfer acknowledge for the vector |
| vecOut | output | 8 | Vector data, zero when not acknowledging |

## Verification
Two functions can fall on the same edge: a local trigger can arrive in the very cycle that the vector delivery clears the pending interrupt. The bench provokes this by raising `trigPulse` together with the data strobes. It then judges the result in three ways. The request line must stay asserted after `xferAck` rises. The scoreboard must see exactly the vector it queued. A second matching acknowledge cycle must then be answered and must clear the request.

// File: rtl/vecIntr_pkg.sv
package vecIntr_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_PASS, S_RESP, S_ACKED, S_WAITAS
  } cycState_t;

  typedef struct packed {
    logic setFwd;
    logic clrFwd;
    logic setAck;
    logic clrAck;
    logic clrPend;
  } ctlStrobes_t;
endpackage

// File: rtl/vecIntrCtl.sv
module vecIntrCtl
  import vecIntr_pkg::*;
#(
  parameter int LVL_W = 3,
  parameter int DS_W  = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             chainIn,
  input  logic             addrStrobe,
  input  logic [LVL_W-1:0] lvlAddr,
  input  logic [DS_W-1:0]  dataStrobe,
  input  logic [LVL_W-1:0] cfgLevel,
  input  logic             pending,
  output ctlStrobes_t      strb
);
  cycState_t state, stateNxt;
  logic cycStart, claim, dsAny;

  assign cycStart = chainIn && addrStrobe;
  assign claim    = pending && (cfgLevel != '0) && (lvlAddr == cfgLevel);
  assign dsAny    = |dataStrobe;

  always_comb begin
    stateNxt = state;
    strb     = '0;
    unique case (state)
      S_IDLE: if (cycStart) begin
        if (claim) stateNxt = S_RESP;
        else begin
          stateNxt    = S_PASS;
          strb.setFwd = 1'b1;
        end
      end
      S_PASS: if (!addrStrobe) begin
        stateNxt    = S_IDLE;
        strb.clrFwd = 1'b1;
      end
      S_RESP: if (dsAny) begin
        stateNxt     = S_ACKED;
        strb.setAck  = 1'b1;
        strb.clrPend = 1'b1;
      end
      S_ACKED: if (!dsAny) begin
        stateNxt    = S_WAITAS;
        strb.clrAck = 1'b1;
      end
      S_WAITAS: if (!addrStrobe) stateNxt = S_IDLE;
      default: stateNxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNxt;
  end

  // R2: a cycle seen with nothing pending is always passed on
  assert_nopend_forwards_R2: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE && cycStart && !pending) |=> (state == S_PASS));
endmodule

// File: rtl/vecIntrDp.sv
module vecIntrDp
  import vecIntr_pkg::*;
#(
  parameter int NUM_LVL = 7,
  parameter int LVL_W   = 3,
  parameter int VEC_W   = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               trigPulse,
  input  logic [LVL_W-1:0]   cfgLevel,
  input  logic [VEC_W-1:0]   cfgVector,
  input  ctlStrobes_t        strb,
  output logic [NUM_LVL-1:0] irqOut,
  output logic               chainOut,
  output logic               xferAck,
  output logic [VEC_W-1:0]   vecOut,
  output logic               pending
);
  logic armOk;
  assign armOk = trigPulse && (cfgLevel != '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending  <= 1'b0;
      chainOut <= 1'b0;
      xferAck  <= 1'b0;
      vecOut   <= '0;
    end else begin
      if (armOk)             pending <= 1'b1;
      else if (strb.clrPend) pending <= 1'b0;
      if (strb.setFwd)       chainOut <= 1'b1;
      else if (strb.clrFwd)  chainOut <= 1'b0;
      if (strb.setAck) begin
        xferAck <= 1'b1;
        vecOut  <= cfgVector;
      end else if (strb.clrAck) begin
        xferAck <= 1'b0;
        vecOut  <= '0;
      end
    end
  end

  for (genvar g = 0; g < NUM_LVL; g++) begin : gLine
    assign irqOut[g] = pending && (cfgLevel == LVL_W'(g + 1));
  end

  assert_one_line_R1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(irqOut));
  assert_deliver_clears_R4: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(xferAck) && !$past(trigPulse)) |-> !pending);
  assert_vec_quiet_R5: assert property (@(posedge clk) disable iff (!rstN)
    !xferAck |-> (vecOut == '0));
endmodule

// File: rtl/vecIntr.sv
module vecIntr
  import vecIntr_pkg::*;
#(
  parameter int NUM_LVL = 7,
  parameter int VEC_W   = 8,
  parameter int DS_W    = 2,
  localparam int LVL_W  = $clog2(NUM_LVL + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               trigPulse,
  input  logic [LVL_W-1:0]   cfgLevel,
  input  logic [VEC_W-1:0]   cfgVector,
  input  logic               chainIn,
  input  logic               addrStrobe,
  input  logic [LVL_W-1:0]   lvlAddr,
  input  logic [DS_W-1:0]    dataStrobe,
  output logic [NUM_LVL-1:0] irqOut,
  output logic               chainOut,
  output logic               xferAck,
  output logic [VEC_W-1:0]   vecOut
);
  ctlStrobes_t strb;
  logic pending;

  vecIntrCtl #(.LVL_W(LVL_W), .DS_W(DS_W)) uCtl (
    .clk(clk), .rstN(rstN), .chainIn(chainIn), .addrStrobe(addrStrobe),
    .lvlAddr(lvlAddr), .dataStrobe(dataStrobe), .cfgLevel(cfgLevel),
    .pending(pending), .strb(strb));

  vecIntrDp #(.NUM_LVL(NUM_LVL), .LVL_W(LVL_W), .VEC_W(VEC_W)) uDp (
    .clk(clk), .rstN(rstN), .trigPulse(trigPulse), .cfgLevel(cfgLevel),
    .cfgVector(cfgVector), .strb(strb), .irqOut(irqOut), .chainOut(chainOut),
    .xferAck(xferAck), .vecOut(vecOut), .pending(pending));

  assert_claim_blocks_chain_R3: assert property (@(posedge clk) disable iff (!rstN)
    xferAck |-> !chainOut);
  assert_chain_follows_as_R6: assert property (@(posedge clk) disable iff (!rstN)
    chainOut |-> $past(addrStrobe));
endmodule

// File: tb/sim_vecIntr.sv
`timescale 1ns/1ps
module sim_vecIntr;
  logic clk = 0, rstN = 0, trigPulse = 0, chainIn = 0, addrStrobe = 0;
  logic [2:0] cfgLevel = 3'd3, lvlAddr = 0;
  logic [7:0] cfgVector = 8'h3C;
  logic [1:0] dataStrobe = 0;
  logic [6:0] irqOut;
  logic chainOut, xferAck;
  logic [7:0] vecOut;
  int nChk = 0, nBad = 0;
  logic [7:0] expQ[$];
  logic prevAck = 0;

  always #2.5 clk = ~clk;

  vecIntr u0 (.clk(clk), .rstN(rstN), .trigPulse(trigPulse), .cfgLevel(cfgLevel),
    .cfgVector(cfgVector), .chainIn(chainIn), .addrStrobe(addrStrobe),
    .lvlAddr(lvlAddr), .dataStrobe(dataStrobe), .irqOut(irqOut),
    .chainOut(chainOut), .xferAck(xferAck), .vecOut(vecOut));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk); endtask

  // scoreboard monitor: each rising acknowledge pops one expected vector
  always @(negedge clk) begin
    if (rstN && xferAck && !prevAck) begin
      if (expQ.size() == 0) chk(0, "R3 unexpected vector", vecOut, 0);
      else begin
        logic [7:0] e;
        e = expQ.pop_front();
        chk(vecOut == e, "R3 vector", vecOut, e);
      end
    end
    prevAck = xferAck;
  end

  task automatic trig();
    trigPulse = 1; step(); trigPulse = 0;
  endtask

  // full matching acknowledge cycle; driver pushes expected vector
  task automatic ackMatch(input logic [2:0] lvl, input bit trigWithDs);
    expQ.push_back(cfgVector);
    chainIn = 1; addrStrobe = 1; lvlAddr = lvl; step();
    chk(chainOut == 0, "R3 chain held", chainOut, 0);
    chk(xferAck == 0, "R3 no early ack", xferAck, 0);
    dataStrobe = 2'b11; trigPulse = trigWithDs; step(); trigPulse = 0;
    chk(xferAck == 1, "R3 ack", xferAck, 1);
    if (trigWithDs)
      chk(irqOut != 0, "R7 request kept", irqOut, 1 << (cfgLevel - 1));
    else
      chk(irqOut == 0, "R4 request cleared", irqOut, 0);
    dataStrobe = 0; step();
    chk(xferAck == 0 && vecOut == 0, "R5 release", {xferAck, vecOut}, 0);
    addrStrobe = 0; chainIn = 0; step();
  endtask

  task automatic ackPass(input logic [2:0] lvl, input string tag);
    chainIn = 1; addrStrobe = 1; lvlAddr = lvl; step();
    chk(chainOut == 1, tag, chainOut, 1);
    dataStrobe = 2'b01; step(); step();
    chk(xferAck == 0 && chainOut == 1, tag, {xferAck, chainOut}, 1);
    dataStrobe = 0; addrStrobe = 0; step();
    chk(chainOut == 0, "R6 chain release", chainOut, 0);
    chainIn = 0; step();
  endtask

  initial begin
    step(); step();
    chk(irqOut == 0 && chainOut == 0 && xferAck == 0 && vecOut == 0,
        "R9 reset", {irqOut, chainOut, xferAck, vecOut}, 0);
    rstN = 1; step();
    trig();
    chk(irqOut == 7'b0000100, "R1 level3 line", irqOut, 7'b0000100);
    ackPass(3'd5, "R2 level mismatch forwards");
    chk(irqOut == 7'b0000100, "R2 request still up", irqOut, 7'b0000100);
    ackMatch(3'd3, 0);
    ackPass(3'd3, "R2 nothing pending forwards");
    // R7: trigger in delivery cycle
    trig();
    ackMatch(3'd3, 1);
    ackMatch(3'd3, 0);
    // level 7 with a new vector
    cfgLevel = 3'd7; cfgVector = 8'hA5; step();
    trig();
    chk(irqOut == 7'b1000000, "R1 level7 line", irqOut, 7'b1000000);
    ackMatch(3'd7, 0);
    // R8: disabled level
    cfgLevel = 3'd0; step();
    trig();
    chk(irqOut == 0, "R8 no request", irqOut, 0);
    ackPass(3'd0, "R8 forwards");
    chk(expQ.size() == 0, "R3 all vectors seen", expQ.size(), 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    #(5.0 * 20000);
    nBad++; nChk++;
    $display("FAIL watchdog R9 actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule